// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC. It decides whether an incoming frame is kept or dropped, using only the frame's 48-bit destination address. The address arrives one octet per cycle, first octet first, with a strobe marking the first octet. The filter keeps a running CRC-32 over the octets as they arrive. One cycle after the sixth octet it raises a single-cycle verdict strobe together with an accept flag.

The filter sorts each address into one of three classes.
- The all-ones address is broadcast, and its verdict comes from a broadcast enable.
- Any other address whose group bit is set is multicast. It is kept when an all-group override is set, or when it falls into a bucket that is marked in a 64-bit hash table. The table is held as a low word and a high word.
- Everything else is unicast, and it is compared with a programmed station address.

A promiscuous override keeps every frame. The host software fills the hash table. The filter only looks up the bucket.

Top module: `mhf_addr_filter`

## Requirements
- R1: The bucket is taken from a CRC-32 over the six address octets, in arrival order. The CRC uses polynomial 0x04C11DB7 and starts at 0xFFFFFFFF, with no final inversion. Within each octet, bit 0 is fed first into an MSB-first shift register. CRC bit 31 picks the table word (0 = `hash_lo`, 1 = `hash_hi`), and CRC bits 30:26 give the bit index inside that word.
- R2: `verdict_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth octet. `verdict_accept` is low whenever `verdict_valid` is low.
- R3: When `promisc_en` is high, every address is accepted, including broadcast with `bcast_en` low.
- R4: If `promisc_en` is low, the all-ones address is accepted exactly when `bcast_en` is high. Neither the hash table nor `allmulti_en` changes this.
- R5: If `promisc_en` is low, a non-broadcast address with its group bit set is accepted when `allmulti_en` is high, whatever the table holds. The group bit is bit 0 of the first octet.
- R6: If `promisc_en` and `allmulti_en` are both low, a non-broadcast group address is accepted exactly when its table bit (see R1) is 1.
- R7: If `promisc_en` is low, an address with group bit 0 is accepted exactly when it equals the station address. Octets 0 and 1 must equal `station_hi[15:8]` and `station_hi[7:0]`. Octets 2 to 5 must equal `station_lo[31:24]` down to `station_lo[7:0]`.
- R8: An octet with `octet_first` high always restarts collection as octet 0. A partial address that was cut short this way gives no verdict.
- R9: Once six octets are taken, further octets without `octet_first` are ignored and give no verdict. This also holds for such octets before the first start.
- R10: Cycles with `octet_valid` low between octets pause collection, without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| octet_valid | input | 1 | Octet strobe |
| octet_first | input | 1 | Marks octet 0 of an address |
| octet_data | input | 8 | Address octet |
| promisc_en | input | 1 | Keep every frame |
| allmulti_en | input | 1 | Keep every group address |
| bcast_en | input | 1 | Keep broadcast |
| station_hi | input | 16 | Station octets 0 and 1 |
| station_lo | input | 32 | Station octets 2 to 5 |
| hash_lo | input | 32 | Table word for CRC bit 31 = 0 |
| hash_hi | input | 32 | Table word for CRC bit 31 = 1 |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Keep frame; qualified by `verdict_valid` |

## Verification
The bench builds the filter with its default parameters: six octets, a 32-bit CRC and two 32-bit table words. These are the only values for which the bucket rule of R1 and the station layout of R7 are defined. With them, random multicast addresses land in both table words and across many of the 64 buckets. Tables that are all-ones in only one word separate the word choice from the index choice. Single-bit and complement tables pin down the index.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  // Destination address classes, in priority order below promiscuous.
  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_MULTICAST = 2'd1,
    CLS_BROADCAST = 2'd2
  } addr_class_e;

  typedef struct packed {
    logic promisc;
    logic allmulti;
    logic bcast;
  } filt_mode_t;

endpackage

// File: rtl/mhf_crc_engine.sv
// Running CRC over octets, one octet per clock, bit 0 of each octet first.
module mhf_crc_engine #(
  parameter int unsigned   OCTET_W = 8,
  parameter int unsigned   CRC_W   = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT = 32'hFFFFFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               octet_en_i,
  input  logic               octet_first_i,
  input  logic [OCTET_W-1:0] octet_i,
  output logic [CRC_W-1:0]   crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] chain [OCTET_W+1];

  always_comb begin
    seed = octet_first_i ? INIT : crc_q;
  end

  assign chain[0] = seed;

  for (genvar b = 0; b < OCTET_W; b++) begin : g_bit
    logic fb;
    assign fb          = chain[b][CRC_W-1] ^ octet_i[b];
    assign chain[b+1]  = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_comb begin
    crc_d = crc_q;
    if (octet_en_i) begin
      crc_d = chain[OCTET_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/mhf_addr_capture.sv
// Collects the destination address octets and signals completion.
module mhf_addr_capture #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned OCTET_W    = 8,
  localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W,
  localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               octet_valid_i,
  input  logic               octet_first_i,
  input  logic [OCTET_W-1:0] octet_i,
  output logic               take_o,
  output logic               take_first_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               done_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              done_q;
  logic              done_d;
  logic              take;
  logic [ADDR_W-1:0] addr_q;

  // Next state: a first octet always restarts, others extend a partial address.
  always_comb begin
    take  = 1'b0;
    cnt_d = cnt_q;
    if (octet_valid_i) begin
      if (octet_first_i) begin
        take  = 1'b1;
        cnt_d = CNT_ONE;
      end else if ((cnt_q != '0) && (cnt_q < CNT_FULL)) begin
        take  = 1'b1;
        cnt_d = cnt_q + CNT_ONE;
      end
    end
    done_d = take && (cnt_d == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // Datapath register: enabled shift, no reset needed.
  always_ff @(posedge clk) begin
    if (take) begin
      addr_q <= {addr_q[ADDR_W-OCTET_W-1:0], octet_i};
    end
  end

  assign take_o       = take;
  assign take_first_o = take & octet_first_i;
  assign addr_o       = addr_q;
  assign done_o       = done_q;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (octet_valid_i && octet_first_i) |=> (cnt_q == CNT_ONE) && !done_o);

endmodule

// File: rtl/mhf_decide.sv
// Classifies the captured address and looks up the verdict.
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned OCTET_W    = 8,
  parameter int unsigned CRC_W      = 32,
  parameter int unsigned TBL_W      = 32,
  localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W,
  localparam int unsigned STA_LO_W  = 4 * OCTET_W,
  localparam int unsigned STA_HI_W  = ADDR_W - STA_LO_W,
  localparam int unsigned IDX_W     = $clog2(TBL_W)
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CRC_W-1:0]    crc_i,
  input  filt_mode_t          mode_i,
  input  logic [STA_HI_W-1:0] station_hi_i,
  input  logic [STA_LO_W-1:0] station_lo_i,
  input  logic [TBL_W-1:0]    tbl_lo_i,
  input  logic [TBL_W-1:0]    tbl_hi_i,
  output addr_class_e         cls_o,
  output logic                accept_o
);

  logic             group_bit;
  logic             all_ones;
  logic             word_sel;
  logic [IDX_W-1:0] bit_idx;
  logic [TBL_W-1:0] tbl_word;
  logic             tbl_hit;
  logic             sta_match;

  always_comb begin
    // Octet 0 sits in the top octet; its bit 0 is the group bit.
    group_bit = addr_i[ADDR_W-OCTET_W];
    all_ones  = &addr_i;
    word_sel  = crc_i[CRC_W-1];
    bit_idx   = crc_i[CRC_W-2 -: IDX_W];
    tbl_word  = word_sel ? tbl_hi_i : tbl_lo_i;
    tbl_hit   = tbl_word[bit_idx];
    sta_match = (addr_i == {station_hi_i, station_lo_i});

    if (all_ones) begin
      cls_o = CLS_BROADCAST;
    end else if (group_bit) begin
      cls_o = CLS_MULTICAST;
    end else begin
      cls_o = CLS_UNICAST;
    end

    if (mode_i.promisc) begin
      accept_o = 1'b1;
    end else begin
      unique case (cls_o)
        CLS_BROADCAST: accept_o = mode_i.bcast;
        CLS_MULTICAST: accept_o = mode_i.allmulti | tbl_hit;
        default:       accept_o = sta_match;
      endcase
    end
  end

endmodule

// File: rtl/mhf_addr_filter.sv
// Receive destination address filter: station match, broadcast, hash bucket.
module mhf_addr_filter
  import mhf_pkg::*;
#(
  parameter int unsigned      ADDR_BYTES = 6,
  parameter int unsigned      OCTET_W    = 8,
  parameter int unsigned      CRC_W      = 32,
  parameter logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] CRC_INIT   = 32'hFFFFFFFF,
  parameter int unsigned      TBL_W      = 32,
  localparam int unsigned     ADDR_W     = ADDR_BYTES * OCTET_W,
  localparam int unsigned     STA_LO_W   = 4 * OCTET_W,
  localparam int unsigned     STA_HI_W   = ADDR_W - STA_LO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                octet_valid,
  input  logic                octet_first,
  input  logic [OCTET_W-1:0]  octet_data,
  input  logic                promisc_en,
  input  logic                allmulti_en,
  input  logic                bcast_en,
  input  logic [STA_HI_W-1:0] station_hi,
  input  logic [STA_LO_W-1:0] station_lo,
  input  logic [TBL_W-1:0]    hash_lo,
  input  logic [TBL_W-1:0]    hash_hi,
  output logic                verdict_valid,
  output logic                verdict_accept
);

  logic              take;
  logic              take_first;
  logic [ADDR_W-1:0] addr;
  logic              done;
  logic [CRC_W-1:0]  crc;
  filt_mode_t        mode;
  addr_class_e       cls;
  logic              accept;

  assign mode = '{promisc: promisc_en, allmulti: allmulti_en, bcast: bcast_en};

  mhf_addr_capture #(
    .ADDR_BYTES (ADDR_BYTES),
    .OCTET_W    (OCTET_W)
  ) u_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .octet_valid_i (octet_valid),
    .octet_first_i (octet_first),
    .octet_i       (octet_data),
    .take_o        (take),
    .take_first_o  (take_first),
    .addr_o        (addr),
    .done_o        (done)
  );

  mhf_crc_engine #(
    .OCTET_W (OCTET_W),
    .CRC_W   (CRC_W),
    .POLY    (CRC_POLY),
    .INIT    (CRC_INIT)
  ) u_crc (
    .clk           (clk),
    .rst_n         (rst_n),
    .octet_en_i    (take),
    .octet_first_i (take_first),
    .octet_i       (octet_data),
    .crc_o         (crc)
  );

  mhf_decide #(
    .ADDR_BYTES (ADDR_BYTES),
    .OCTET_W    (OCTET_W),
    .CRC_W      (CRC_W),
    .TBL_W      (TBL_W)
  ) u_decide (
    .addr_i       (addr),
    .crc_i        (crc),
    .mode_i       (mode),
    .station_hi_i (station_hi),
    .station_lo_i (station_lo),
    .tbl_lo_i     (hash_lo),
    .tbl_hi_i     (hash_hi),
    .cls_o        (cls),
    .accept_o     (accept)
  );

  assign verdict_valid  = done;
  assign verdict_accept = done & accept;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);

  assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> !verdict_accept);

  assert_promisc_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && promisc_en) |-> verdict_accept);

  assert_bcast_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !promisc_en && (cls == CLS_BROADCAST)) |-> (verdict_accept == bcast_en));

  assert_unicast_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && !promisc_en && (cls == CLS_UNICAST) &&
     (addr != {station_hi, station_lo})) |-> !verdict_accept);

endmodule

// File: tb/mhf_addr_filter_tb.sv
`timescale 1ns/1ps
module mhf_addr_filter_tb;

  logic        clk;
  logic        rst_n;
  logic        octet_valid;
  logic        octet_first;
  logic [7:0]  octet_data;
  logic        promisc_en;
  logic        allmulti_en;
  logic        bcast_en;
  logic [15:0] station_hi;
  logic [31:0] station_lo;
  logic [31:0] hash_lo;
  logic [31:0] hash_hi;
  logic        verdict_valid;
  logic        verdict_accept;

  int unsigned vectors;
  int unsigned miscompares;
  int unsigned pulses;
  bit          exp_q[$];
  string       tag_q[$];

  mhf_addr_filter u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .octet_valid    (octet_valid),
    .octet_first    (octet_first),
    .octet_data     (octet_data),
    .promisc_en     (promisc_en),
    .allmulti_en    (allmulti_en),
    .bcast_en       (bcast_en),
    .station_hi     (station_hi),
    .station_lo     (station_lo),
    .hash_lo        (hash_lo),
    .hash_hi        (hash_hi),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference CRC from R1.
  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[31] ^ b[j];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic bit ref_accept(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    if (promisc_en) return 1'b1;
    if (&a) return bcast_en;
    if (a[40]) return allmulti_en | (c[31] ? hash_hi[c[30:26]] : hash_lo[c[30:26]]);
    return a == {station_hi, station_lo};
  endfunction

  function automatic logic [5:0] ref_bucket(input logic [47:0] a);
    logic [31:0] c;
    c = ref_crc(a);
    return c[31:26];
  endfunction

  task automatic drive_octet(input logic [7:0] b, input bit first);
    @(negedge clk);
    octet_valid = 1'b1;
    octet_first = first;
    octet_data  = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      octet_valid = 1'b0;
      octet_first = 1'b0;
      octet_data  = $urandom;
    end
  endtask

  // Driver: push expected verdict, then present the address.
  task automatic send(input logic [47:0] a, input int gap, input string tag);
    exp_q.push_back(ref_accept(a));
    tag_q.push_back(tag);
    for (int i = 0; i < 6; i++) begin
      drive_octet(a[47-8*i -: 8], i == 0);
      if (gap > 0 && i < 5) idle(gap);
    end
    idle(3);
  endtask

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && verdict_valid) begin
      pulses++;
      if (exp_q.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R9 unexpected verdict: actual 1 expected 0");
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (verdict_accept !== e) begin
          miscompares++;
          $display("FAIL %s: actual %0d expected %0d", t, verdict_accept, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [47:0] sta;
    logic [47:0] a;
    int unsigned p0;

    vectors = 0; miscompares = 0; pulses = 0;
    rst_n = 1'b0; octet_valid = 1'b0; octet_first = 1'b0; octet_data = '0;
    promisc_en = 1'b0; allmulti_en = 1'b0; bcast_en = 1'b0;
    sta = 48'h001A_2B3C_4D5E;
    station_hi = sta[47:32]; station_lo = sta[31:0];
    hash_lo = '0; hash_hi = '0;
    repeat (3) @(negedge clk);
    check(verdict_valid == 1'b0 && verdict_accept == 1'b0, "R2 reset", verdict_valid, 0);
    rst_n = 1'b1;
    idle(2);

    // R9: stray octets before any start give nothing.
    p0 = pulses;
    drive_octet(8'h11, 0); drive_octet(8'h22, 0); idle(3);
    check(pulses == p0, "R9 stray before start", pulses - p0, 0);

    // R7 unicast.
    send(sta, 0, "R7 station match");
    send(sta ^ 48'h1, 0, "R7 last octet differs");
    send(sta ^ 48'h0200_0000_0000, 0, "R7 first octet differs");
    send(sta ^ 48'h0000_0100_0000, 0, "R7 octet 2 differs");

    // R4 broadcast.
    bcast_en = 1'b1;
    send('1, 0, "R4 broadcast enabled");
    bcast_en = 1'b0; allmulti_en = 1'b1; hash_lo = '1; hash_hi = '1;
    send('1, 0, "R4 broadcast disabled despite table");
    allmulti_en = 1'b0;

    // R1 word selection: only one table word populated.
    for (int i = 0; i < 8; i++) begin
      a = {8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'(i * 37 + 1)};
      hash_lo = '0; hash_hi = '1;
      send(a, 0, "R1 high word only");
      hash_lo = '1; hash_hi = '0;
      send(a, 0, "R1 low word only");
    end

    // R6 single bucket bit and its complement.
    for (int i = 0; i < 6; i++) begin
      logic [5:0] bk;
      a = {8'h33, 8'h33, 8'(i), 8'hA5, 8'h00, 8'(i + 7)};
      bk = ref_bucket(a);
      hash_lo = '0; hash_hi = '0;
      if (bk[5]) hash_hi[bk[4:0]] = 1'b1; else hash_lo[bk[4:0]] = 1'b1;
      send(a, 0, "R6 bucket bit set");
      hash_lo = ~hash_lo; hash_hi = ~hash_hi;
      send(a, 0, "R6 bucket bit clear");
    end

    // R5 all-group override with an empty table.
    hash_lo = '0; hash_hi = '0; allmulti_en = 1'b1;
    send(48'h0100_5E7F_0001, 0, "R5 allmulti group");
    send(sta ^ 48'h4, 0, "R5 allmulti unicast mismatch");
    allmulti_en = 1'b0;
    send(48'h0100_5E7F_0001, 0, "R5 allmulti off");

    // R3 promiscuous.
    promisc_en = 1'b1;
    send(sta ^ 48'h55, 0, "R3 promisc unicast");
    send('1, 0, "R3 promisc broadcast");
    send(48'h0300_0000_0009, 0, "R3 promisc multicast");
    promisc_en = 1'b0;

    // R8 restart mid-address.
    drive_octet(8'hFF, 1); drive_octet(8'hFF, 0); drive_octet(8'hFF, 0);
    send(sta, 0, "R8 restart");
    p0 = pulses;
    drive_octet(8'h01, 1); drive_octet(8'h02, 0); drive_octet(8'h03, 0);
    drive_octet(8'h04, 0); drive_octet(8'h05, 0);
    drive_octet(8'h00, 1); idle(3);
    check(pulses == p0, "R8 cut-short address", pulses - p0, 0);
    idle(5);

    // R10 gaps between octets.
    send(sta, 2, "R10 gapped match");
    send(sta ^ 48'h100, 1, "R10 gapped mismatch");

    // R9 extra octets after a complete address.
    p0 = pulses;
    send(sta, 0, "R9 base");
    drive_octet(8'hAA, 0); drive_octet(8'hBB, 0); drive_octet(8'hCC, 0); drive_octet(8'hDD, 0);
    idle(4);
    check(pulses == p0 + 1, "R9 extra octets", pulses - p0, 1);

    // Mixed random traffic (R6/R7 under random configuration).
    for (int i = 0; i < 60; i++) begin
      a = {$urandom, $urandom};
      if (i % 5 == 0) a = sta;
      hash_lo = $urandom; hash_hi = $urandom;
      allmulti_en = ($urandom % 4) == 0;
      bcast_en = $urandom;
      promisc_en = ($urandom % 8) == 0;
      send(a, i % 3, "R6 random mix");
    end

    idle(10);
    while (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      check(1'b0, "R2 missing verdict", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule